// File: doc/BRIEF.md
# Triggered Sample Playback Sequencer

This block plays a table of stored samples out to a converter's data registers at a steady update rate. The host fills a small synchronous sample memory through a write port and sets how many updates a pass contains. It then enables memory mode and arms the unit. A software trigger pulse or a rising edge on the external trigger pin starts a pass. On every update tick the sequencer reads the next word from memory and presents it on `dac_data` with a one-cycle `dac_wr` strobe. The read address steps up by one each time.

The update tick comes from one of two sources. The first is an internal divider with a fixed 1-2-5 ladder of thirteen rates, from 10 kHz down to 1 Hz, scaled from a base period given in system clock cycles. The second is the rising edges of an external clock pin. A one-shot pass stops after the programmed count and can raise a sticky interrupt. In continuous mode the address returns to zero and the pass repeats without any interrupt. Only data words come from memory; converter command words are set elsewhere and are never touched here.

Top module: `sample_playback_seq`

## Requirements
- R1: After reset, `busy`, `irq` and `dac_wr` are 0 and `dac_data` is 0.
- R2: A pass starts only if `cfg_arm` and `cfg_mem_mode` are both 1 and `cfg_count` is non-zero. The start cause is a `sw_trig` pulse or a rising edge of `ext_trig`. Any other trigger is ignored.
- R3: A trigger that arrives while a pass is running is ignored. The running sequence continues without a restart.
- R4: Each update tick reads the next memory word, starting at address 0 and stepping by one. That word appears on `dac_data` with `dac_wr` high for one cycle, two cycles after the tick.
- R5: With `cfg_ext_clk`=0, updates are spaced BASE_DIV×M system cycles apart. Rate code k (0..12) gives M = {1,2,5}[k mod 3]×10^(k div 3), so code 0 is the fastest (10 kHz) and code 12 is the slowest (1 Hz). Codes 13..15 behave as code 12.
- R6: With `cfg_ext_clk`=1, exactly one update is made per rising edge of `ext_clk` while a pass runs. Edges are seen after the synchronizer, and no internal-rate updates occur.
- R7: In one-shot mode (`cfg_cont`=0), exactly `cfg_count` updates are made, then `busy` falls. `irq` is set at the end only if `cfg_irq_en` is 1.
- R8: `irq` is sticky. It stays 1 until a cycle with `irq_clr`=1 clears it, and a new set in the same cycle wins.
- R9: In continuous mode, the address wraps to 0 after `cfg_count` updates and the pass repeats with no interrupt. If `cfg_cont` is cleared during a run, the current pass finishes and the block stops as in one-shot mode.
- R10: Clearing `cfg_arm` or `cfg_mem_mode` during a run drops `busy` on the next cycle, and no further updates are made. The next valid trigger starts again from address 0.
- R11: `ext_trig` and `ext_clk` are synchronized into the `clk` domain. Only their rising edges act.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mem_we | input | 1 | Sample memory write enable |
| mem_waddr | input | AW | Sample memory write address |
| mem_wdata | input | DW | Sample memory write data |
| cfg_count | input | AW+1 | Number of updates per pass |
| cfg_mem_mode | input | 1 | Memory playback mode enable |
| cfg_arm | input | 1 | Arm bit |
| cfg_cont | input | 1 | Continuous (wrap) mode |
| cfg_irq_en | input | 1 | Interrupt enable |
| cfg_ext_clk | input | 1 | 1 selects external update clock |
| cfg_rate_sel | input | 4 | Internal rate code |
| sw_trig | input | 1 | Software trigger pulse |
| ext_trig | input | 1 | Asynchronous external trigger |
| ext_clk | input | 1 | Asynchronous external update clock |
| irq_clr | input | 1 | Write-1 clear of the interrupt flag |
| dac_data | output | DW | Data word for the converter registers |
| dac_wr | output | 1 | One-cycle strobe marking a new data word |
| busy | output | 1 | Pass in progress |
| irq | output | 1 | Sticky end-of-pass interrupt flag |

## Verification
The update tick is registered, and the memory read adds one more register, so each data word and its `dac_wr` strobe arrive two cycles after the tick. The bench therefore does not predict absolute cycles. Its scoreboard holds the expected words in order, and the monitor compares each strobe against the head of the queue. The monitor also measures the gap between consecutive strobes against BASE_DIV×M. Control effects such as `busy` falling after arm is cleared are sampled a cycle or more after the input changes. The synchronizers add two to three cycles, and the trigger and external-clock tests wait well beyond that before checking.

// File: rtl/sps_pkg.sv
package sps_pkg;
   localparam int RATE_CODES = 13;

   // Divider multiple for a rate code on the 1-2-5 ladder; codes above 12 fall to 1 Hz.
   function automatic logic [31:0] rate_mult(input int code);
      int c;
      logic [31:0] m;
      c = (code > RATE_CODES - 1) ? RATE_CODES - 1 : code;
      m = ((c % 3) == 0) ? 32'd1 : (((c % 3) == 1) ? 32'd2 : 32'd5);
      for (int i = 0; i < c / 3; i++) m = m * 32'd10;
      return m;
   endfunction
endpackage

// File: rtl/sps_sync_edge.sv
module sps_sync_edge #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_in,
   output logic rise
);
   if (STAGES < 2) begin : g_bad_stages
      $error("sps_sync_edge: STAGES must be at least 2");
   end

   logic [STAGES:0] sh;

   for (genvar s = 0; s <= STAGES; s++) begin : g_stage
      always_ff @(posedge clk) begin
         if (!rst_n) sh[s] <= 1'b0;
         else if (s == 0) sh[s] <= async_in;
         else sh[s] <= sh[(s == 0) ? 0 : s - 1];
      end
   end

   assign rise = sh[STAGES-1] & ~sh[STAGES];
endmodule

// File: rtl/sps_sample_ram.sv
module sps_sample_ram #(
   parameter int DW = 16,
   parameter int AW = 6
) (
   input  logic          clk,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [DW-1:0] wdata,
   input  logic          re,
   input  logic [AW-1:0] raddr,
   output logic [DW-1:0] q
);
   localparam int DEPTH = 1 << AW;

   if (AW < 1 || AW > 12) begin : g_bad_aw
      $error("sps_sample_ram: AW out of range 1..12");
   end

   logic [DW-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) mem[waddr] <= wdata;
      if (re) q <= mem[raddr];
   end
endmodule

// File: rtl/sps_rate_tick.sv
module sps_rate_tick
   import sps_pkg::*;
#(
   parameter int BASE_DIV = 5000
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       run,
   input  logic       ext_sel,
   input  logic [3:0] rate_sel,
   input  logic       ext_rise,
   output logic       tick
);
   if (BASE_DIV < 1) begin : g_bad_div
      $error("sps_rate_tick: BASE_DIV must be at least 1");
   end

   logic [31:0] period_tab [16];
   logic [31:0] period;
   logic [31:0] div_q;
   logic        int_tick;

   for (genvar k = 0; k < 16; k++) begin : g_rate
      assign period_tab[k] = 32'(BASE_DIV) * rate_mult(k);
   end

   assign period   = period_tab[rate_sel];
   assign int_tick = run && (div_q >= period - 32'd1);

   always_ff @(posedge clk) begin
      if (!rst_n || !run || ext_sel) div_q <= '0;
      else if (int_tick)             div_q <= '0;
      else                           div_q <= div_q + 32'd1;
   end

   assign tick = ext_sel ? (run & ext_rise) : (int_tick & ~ext_sel);
endmodule

// File: rtl/sample_playback_seq.sv
module sample_playback_seq #(
   parameter int DW          = 16,
   parameter int AW          = 6,
   parameter int BASE_DIV    = 5000,
   parameter int SYNC_STAGES = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          mem_we,
   input  logic [AW-1:0] mem_waddr,
   input  logic [DW-1:0] mem_wdata,
   input  logic [AW:0]   cfg_count,
   input  logic          cfg_mem_mode,
   input  logic          cfg_arm,
   input  logic          cfg_cont,
   input  logic          cfg_irq_en,
   input  logic          cfg_ext_clk,
   input  logic [3:0]    cfg_rate_sel,
   input  logic          sw_trig,
   input  logic          ext_trig,
   input  logic          ext_clk,
   input  logic          irq_clr,
   output logic [DW-1:0] dac_data,
   output logic          dac_wr,
   output logic          busy,
   output logic          irq
);
   localparam int CW = AW + 1;

   if (DW < 1) begin : g_bad_dw
      $error("sample_playback_seq: DW must be positive");
   end

   logic          trig_rise, eclk_rise, tick;
   logic          start, enabled, last_pos, rd_v, irq_set;
   logic [CW-1:0] pos;
   logic [DW-1:0] ram_q;

   sps_sync_edge #(.STAGES(SYNC_STAGES)) u_trig_sync (
      .clk(clk), .rst_n(rst_n), .async_in(ext_trig), .rise(trig_rise));

   sps_sync_edge #(.STAGES(SYNC_STAGES)) u_eclk_sync (
      .clk(clk), .rst_n(rst_n), .async_in(ext_clk), .rise(eclk_rise));

   sps_rate_tick #(.BASE_DIV(BASE_DIV)) u_tick (
      .clk(clk), .rst_n(rst_n), .run(busy), .ext_sel(cfg_ext_clk),
      .rate_sel(cfg_rate_sel), .ext_rise(eclk_rise), .tick(tick));

   sps_sample_ram #(.DW(DW), .AW(AW)) u_ram (
      .clk(clk), .we(mem_we), .waddr(mem_waddr), .wdata(mem_wdata),
      .re(busy & enabled & tick), .raddr(pos[AW-1:0]), .q(ram_q));

   assign enabled  = cfg_arm & cfg_mem_mode;
   assign start    = enabled & ~busy & (sw_trig | trig_rise) & (cfg_count != '0);
   assign last_pos = (pos == cfg_count - CW'(1));
   assign irq_set  = busy & enabled & tick & last_pos & ~cfg_cont & cfg_irq_en;

   // Sequencer: position counter and run flag.
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy <= 1'b0;
         pos  <= '0;
         rd_v <= 1'b0;
      end else begin
         rd_v <= 1'b0;
         if (busy && !enabled) begin
            busy <= 1'b0;
         end else if (start) begin
            busy <= 1'b1;
            pos  <= '0;
         end else if (busy && tick) begin
            rd_v <= 1'b1;
            if (last_pos) begin
               pos <= '0;
               if (!cfg_cont) busy <= 1'b0;
            end else begin
               pos <= pos + CW'(1);
            end
         end
      end
   end

   // Output stage: register the memory word and strobe it.
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         dac_data <= '0;
         dac_wr   <= 1'b0;
      end else begin
         dac_wr <= rd_v;
         if (rd_v) dac_data <= ram_q;
      end
   end

   // Sticky interrupt flag; a set in the same cycle as a clear wins.
   always_ff @(posedge clk) begin
      if (!rst_n)       irq <= 1'b0;
      else if (irq_set) irq <= 1'b1;
      else if (irq_clr) irq <= 1'b0;
   end
endmodule

// File: rtl/sps_checker.sv
module sps_checker (
   input logic clk,
   input logic rst_n,
   input logic cfg_arm,
   input logic cfg_mem_mode,
   input logic cfg_cont,
   input logic cfg_irq_en,
   input logic irq_clr,
   input logic dac_wr,
   input logic busy,
   input logic irq
);
   AST_WR_AFTER_RUN: assert property (@(posedge clk) disable iff (!rst_n)
      dac_wr |-> $past(busy, 2)); // R4
   AST_UNARMED_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !cfg_arm) |=> !busy); // R2
   AST_NOMEM_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !cfg_mem_mode) |=> !busy); // R2
   AST_DISARM_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !cfg_arm) |=> !busy); // R10
   AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (irq && !irq_clr) |=> irq); // R8
   AST_IRQ_ONESHOT_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq) |-> $past(!cfg_cont && cfg_irq_en && busy)); // R9
endmodule

bind sample_playback_seq sps_checker u_sps_checker (
   .clk(clk), .rst_n(rst_n), .cfg_arm(cfg_arm), .cfg_mem_mode(cfg_mem_mode),
   .cfg_cont(cfg_cont), .cfg_irq_en(cfg_irq_en), .irq_clr(irq_clr),
   .dac_wr(dac_wr), .busy(busy), .irq(irq));

// File: tb/sample_playback_seq_test.sv
module sample_playback_seq_test;
   localparam int DW = 16;
   localparam int AW = 6;
   localparam int BD = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          mem_we = 1'b0;
   logic [AW-1:0] mem_waddr = '0;
   logic [DW-1:0] mem_wdata = '0;
   logic [AW:0]   cfg_count = '0;
   logic          cfg_mem_mode = 1'b0, cfg_arm = 1'b0, cfg_cont = 1'b0;
   logic          cfg_irq_en = 1'b0, cfg_ext_clk = 1'b0;
   logic [3:0]    cfg_rate_sel = '0;
   logic          sw_trig = 1'b0, ext_trig = 1'b0, ext_clk = 1'b0, irq_clr = 1'b0;
   logic [DW-1:0] dac_data;
   logic          dac_wr, busy, irq;

   int checks = 0, failures = 0, cyc = 0, last_wr = 0, exp_gap = 0, wr_seen = 0;
   bit have_prev = 0, finished = 0;
   logic [DW-1:0] exp_q[$];

   always #10 clk = ~clk;

   sample_playback_seq #(.DW(DW), .AW(AW), .BASE_DIV(BD), .SYNC_STAGES(2)) uut (
      .clk(clk), .rst_n(rst_n), .mem_we(mem_we), .mem_waddr(mem_waddr),
      .mem_wdata(mem_wdata), .cfg_count(cfg_count), .cfg_mem_mode(cfg_mem_mode),
      .cfg_arm(cfg_arm), .cfg_cont(cfg_cont), .cfg_irq_en(cfg_irq_en),
      .cfg_ext_clk(cfg_ext_clk), .cfg_rate_sel(cfg_rate_sel), .sw_trig(sw_trig),
      .ext_trig(ext_trig), .ext_clk(ext_clk), .irq_clr(irq_clr),
      .dac_data(dac_data), .dac_wr(dac_wr), .busy(busy), .irq(irq));

   function automatic logic [DW-1:0] word_at(int a);
      return DW'(16'h1000 + a * 16'h0111);
   endfunction

   task automatic check(bit ok, string req, string what, longint act, longint exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic push_pass(int n);
      for (int i = 0; i < n; i++) exp_q.push_back(word_at(i));
   endtask

   task automatic pulse_sw;
      @(negedge clk) sw_trig = 1'b1;
      @(negedge clk) sw_trig = 1'b0;
   endtask

   task automatic wait_done(string req);
      int n = 0;
      while ((busy || exp_q.size() != 0) && n < 100000) begin
         @(negedge clk); n++;
      end
      repeat (4) @(negedge clk);
      check(exp_q.size() == 0, req, "all expected words delivered", exp_q.size(), 0);
      check(busy == 1'b0, req, "busy low after pass", busy, 0);
   endtask

   // Monitor: pops the scoreboard on each strobe and checks spacing.
   always @(posedge clk) begin
      #1;
      cyc++;
      if (dac_wr) begin
         wr_seen++;
         if (exp_q.size() == 0) begin
            check(0, "R4", "unexpected dac_wr", dac_data, 0);
         end else begin
            logic [DW-1:0] e;
            e = exp_q.pop_front();
            check(dac_data == e, "R4", "dac_data word order", dac_data, e);
         end
         if (have_prev && exp_gap != 0)
            check(cyc - last_wr == exp_gap, "R5", "update spacing", cyc - last_wr, exp_gap);
         have_prev = 1;
         last_wr = cyc;
      end
   end

   initial begin
      repeat (190000) @(posedge clk);
      if (!finished) begin
         failures++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      int base;
      repeat (3) @(negedge clk);
      // R1: reset state
      check(busy == 0 && irq == 0 && dac_wr == 0, "R1", "control outputs at reset",
            {busy, irq, dac_wr}, 0);
      check(dac_data == 0, "R1", "dac_data at reset", dac_data, 0);
      rst_n = 1'b1;
      for (int i = 0; i < 16; i++) begin
         @(negedge clk);
         mem_we = 1'b1; mem_waddr = AW'(i); mem_wdata = word_at(i);
      end
      @(negedge clk) mem_we = 1'b0;

      // R2: triggers ignored while unarmed or outside memory mode
      cfg_count = 5; cfg_mem_mode = 1'b1; cfg_arm = 1'b0;
      pulse_sw(); repeat (20) @(negedge clk);
      check(busy == 0 && wr_seen == 0, "R2", "trigger while unarmed", busy, 0);
      cfg_arm = 1'b1; cfg_mem_mode = 1'b0;
      pulse_sw(); repeat (20) @(negedge clk);
      check(busy == 0 && wr_seen == 0, "R2", "trigger outside memory mode", busy, 0);
      cfg_mem_mode = 1'b1; cfg_count = 0;
      pulse_sw(); repeat (20) @(negedge clk);
      check(busy == 0 && wr_seen == 0, "R2", "trigger with zero count", busy, 0);

      // R7, R3, R5: one-shot pass at the fastest rate with a retrigger mid-run
      cfg_count = 5; cfg_irq_en = 1'b1; cfg_rate_sel = 0; exp_gap = BD; have_prev = 0;
      push_pass(5);
      base = wr_seen;
      pulse_sw();
      wait (wr_seen == base + 2);
      pulse_sw(); // R3: ignored while running
      wait_done("R7");
      check(wr_seen - base == 5, "R3", "retrigger did not restart", wr_seen - base, 5);
      check(irq == 1'b1, "R7", "irq set after one-shot", irq, 1);

      // R8: sticky irq then cleared
      repeat (10) @(negedge clk);
      check(irq == 1'b1, "R8", "irq holds without clear", irq, 1);
      @(negedge clk) irq_clr = 1'b1;
      @(negedge clk) irq_clr = 1'b0;
      check(irq == 1'b0, "R8", "irq cleared by irq_clr", irq, 0);

      // R5: rate code 2 (x5) and unused code 14 (as code 12, x10000), irq disabled
      cfg_irq_en = 1'b0; cfg_count = 3; cfg_rate_sel = 2; exp_gap = 5 * BD; have_prev = 0;
      push_pass(3); pulse_sw(); wait_done("R5");
      check(irq == 1'b0, "R7", "no irq when disabled", irq, 0);
      cfg_count = 2; cfg_rate_sel = 14; exp_gap = 10000 * BD; have_prev = 0;
      push_pass(2); pulse_sw(); wait_done("R5");

      // R9: continuous wrap, then cont cleared finishes the pass
      cfg_irq_en = 1'b1; cfg_cont = 1'b1; cfg_count = 3; cfg_rate_sel = 0;
      exp_gap = BD; have_prev = 0;
      push_pass(3); push_pass(3); push_pass(3);
      base = wr_seen;
      pulse_sw();
      wait (wr_seen == base + 7);
      @(negedge clk);
      check(irq == 1'b0, "R9", "no irq across wrap", irq, 0);
      check(busy == 1'b1, "R9", "still running after wrap", busy, 1);
      cfg_cont = 1'b0;
      wait_done("R9");
      check(wr_seen - base == 9, "R9", "pass finished after cont cleared", wr_seen - base, 9);
      @(negedge clk) irq_clr = 1'b1;
      @(negedge clk) irq_clr = 1'b0;

      // R10: disarm mid-run, then restart from address 0
      cfg_irq_en = 1'b0; cfg_count = 10; have_prev = 0;
      push_pass(3);
      base = wr_seen;
      pulse_sw();
      wait (wr_seen == base + 3);
      @(negedge clk) cfg_arm = 1'b0;
      repeat (2) @(negedge clk);
      check(busy == 1'b0, "R10", "busy drops after disarm", busy, 0);
      repeat (30) @(negedge clk);
      check(wr_seen - base == 3, "R10", "no updates after disarm", wr_seen - base, 3);
      cfg_arm = 1'b1; cfg_count = 2; have_prev = 0;
      push_pass(2); pulse_sw(); wait_done("R10");

      // R11: external trigger rising edge starts a pass
      cfg_count = 2; have_prev = 0;
      push_pass(2);
      @(negedge clk) ext_trig = 1'b1;
      wait_done("R11");
      @(negedge clk) ext_trig = 1'b0;

      // R6: external update clock
      cfg_ext_clk = 1'b1; cfg_count = 3; exp_gap = 0; have_prev = 0;
      push_pass(3);
      base = wr_seen;
      pulse_sw();
      repeat (40) @(negedge clk);
      check(wr_seen == base, "R6", "no updates without ext_clk edges", wr_seen - base, 0);
      for (int e = 0; e < 3; e++) begin
         @(negedge clk) ext_clk = 1'b1;
         repeat (12) @(negedge clk);
         ext_clk = 1'b0;
         repeat (12) @(negedge clk);
         check(wr_seen - base == e + 1, "R6", "one update per ext_clk edge", wr_seen - base, e + 1);
      end
      wait_done("R6");
      @(negedge clk) ext_clk = 1'b1;
      repeat (12) @(negedge clk);
      ext_clk = 1'b0;
      check(wr_seen - base == 3, "R6", "edge after pass ignored", wr_seen - base, 3);

      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule